// File: doc/BRIEF.md
# Dual-Rate Machine-Cycle Clock Generator

This block sits between the oscillator and the phase generator of an 8-bit controller core. It turns the oscillator into a single-cycle clock-enable, `core_ce`, which the core and the on-chip peripherals use in place of a derived clock. In standard rate the oscillator first passes through a divide-by-two stage, so a machine cycle of six states lasts twelve oscillator periods. In double rate the divide stage is bypassed, so a machine cycle lasts six oscillator periods. Every timer or serial-port rate derived from the enable therefore doubles in double rate.

Software selects the rate through bit 0 of a clock-control register at SFR address 8Fh. The register is written through a plain SFR write strobe. A newly written rate is not applied at once. It is applied on the next rising edge of the divided clock, so a change in either direction never produces a shortened or stretched enable interval. A six-state sequencer advances on each enable. It outputs the current state number, a one-hot per-state strobe and a machine-cycle-start strobe.

Top module: `mcyc_clkgen`

## Requirements
- R1: While reset (`rst_n` low) is applied at a clock edge, the block enters standard rate: `dbl_mode`=0, `half_clk`=0, `core_ce`=0, `state_num`=6, `state_stb`=0 and `mcyc_start`=0. This holds even if double rate was active before.
- R2: In standard rate `core_ce` is high in every second oscillator cycle, and `mcyc_start` recurs every 12 oscillator cycles.
- R3: In double rate `core_ce` is high in every oscillator cycle, and `mcyc_start` recurs every 6 oscillator cycles.
- R4: A write with `sfr_we`=1 and `sfr_addr`=8Fh sets the requested rate to `sfr_wdata` bit 0 (0 = standard, 1 = double). Bits 7..1 of the data have no effect, and writes to any other address leave the rate unchanged.
- R5: The applied rate (`dbl_mode`) changes only at a clock edge at which `half_clk` rises from 0 to 1. After the write edge it follows 1 cycle later if `half_clk` reads 0 just after that edge, and 2 cycles later if it reads 1.
- R6: During and after any rate change, consecutive `core_ce` pulses are never more than 2 oscillator cycles apart.
- R7: `state_num` steps 1,2,...,6,1,... once per `core_ce`. In the cycle after each `core_ce`, exactly one bit of `state_stb` is high: bit (`state_num`-1). At all other times `state_stb` is 0.
- R8: `mcyc_start` is high for one cycle when the sequencer enters state 1, once per machine cycle.
- R9: With `sfr_we`=0, the address and data inputs have no effect on the rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_we | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR write address |
| sfr_wdata | input | 8 | SFR write data |
| core_ce | output | 1 | Core/peripheral clock enable, one cycle per core clock |
| half_clk | output | 1 | Level of the divided-by-two clock |
| dbl_mode | output | 1 | Applied rate: 1 = double, 0 = standard |
| state_num | output | 3 | Current machine-cycle state, 1..6 |
| state_stb | output | 6 | One-hot strobe of the state just entered |
| mcyc_start | output | 1 | Machine-cycle-start strobe (state 1 entered) |

## Verification
The register bit is captured at the write edge. The applied rate follows one or two edges later, depending on the `half_clk` level the bench reads right after the write edge. The bench predicts that latency exactly and samples `dbl_mode` at each falling edge in between. The state strobes and `mcyc_start` come from registers, so they appear in the cycle after the enabling `core_ce`. The bench measures periods from one `mcyc_start` sample to the next, starting only after a settle window of four cycles. Inputs are driven one nanosecond after a rising edge and all outputs are read on falling edges, so no check races a register update.

// File: rtl/mcyc_clkgen_pkg.sv
// Shared constants and types for the dual-rate machine-cycle clock generator.
package mcyc_clkgen_pkg;
    localparam int DEF_SFR_AW   = 8;
    localparam int DEF_SFR_DW   = 8;
    localparam int DEF_CTL_ADDR = 'h8F;
    localparam int DEF_MODE_BIT = 0;
    localparam int DEF_N_STATES = 6;

    typedef enum logic {
        CLK_STD = 1'b0,
        CLK_DBL = 1'b1
    } clk_mode_e;
endpackage

// File: rtl/mcyc_ctl_reg.sv
// Clock-control register: holds the requested rate bit.
// Assumes a single-cycle write strobe. Only the selected data bit at the
// decoded address is stored; all other bits and addresses are dropped.
module mcyc_ctl_reg
    import mcyc_clkgen_pkg::*;
#(
    parameter int SFR_AW   = DEF_SFR_AW,
    parameter int SFR_DW   = DEF_SFR_DW,
    parameter int CTL_ADDR = DEF_CTL_ADDR,
    parameter int MODE_BIT = DEF_MODE_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SFR_AW-1:0] addr,
    input  logic [SFR_DW-1:0] wdata,
    output clk_mode_e         mode_req
);
    localparam logic [SFR_AW-1:0] ADDR_MATCH = SFR_AW'(CTL_ADDR);

    logic hit;
    assign hit = we && (addr == ADDR_MATCH);

    // Capture the requested rate on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_req <= CLK_STD;
        end else if (hit) begin
            mode_req <= clk_mode_e'(wdata[MODE_BIT]);
        end
    end
endmodule

// File: rtl/mcyc_div_switch.sv
// Divide-by-two stage with synchronised rate switch.
// The divider toggles every oscillator cycle. The requested rate is applied
// only at the edge where the divided clock rises, so the enable interval
// is always 1 or 2 cycles and never a runt.
module mcyc_div_switch
    import mcyc_clkgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  clk_mode_e mode_req,
    output logic      half_clk,
    output clk_mode_e mode_act,
    output logic      core_ce
);
    logic half_q;

    // Toggle the divider; apply a new rate on its rising edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q   <= 1'b0;
            mode_act <= CLK_STD;
        end else begin
            half_q <= ~half_q;
            if (!half_q) begin
                mode_act <= mode_req;
            end
        end
    end

    // Enable: every cycle in double rate, divided-clock high phase otherwise.
    always_comb begin
        core_ce = (mode_act == CLK_DBL) || half_q;
    end

    assign half_clk = half_q;
endmodule

// File: rtl/mcyc_state_seq.sv
// Machine-cycle state sequencer.
// Advances one state per core enable through N_STATES states. It emits a
// registered one-hot strobe for the state just entered, valid in the cycle
// after the enable. Reset parks it on the last state so the first enable
// enters state 1.
module mcyc_state_seq
    import mcyc_clkgen_pkg::*;
#(
    parameter int N_STATES = DEF_N_STATES,
    localparam int SW      = $clog2(N_STATES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                core_ce,
    output logic [SW-1:0]       state_num,
    output logic [N_STATES-1:0] state_stb,
    output logic                mcyc_start
);
    localparam logic [SW-1:0] LAST = SW'(N_STATES - 1);

    logic [SW-1:0] st_q;
    logic [SW-1:0] st_nxt;

    // Next-state index with wrap.
    always_comb begin
        st_nxt = (st_q == LAST) ? '0 : st_q + SW'(1);
    end

    // Hold the state index, advancing on each enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= LAST;
        end else if (core_ce) begin
            st_q <= st_nxt;
        end
    end

    // Register one strobe bit per state.
    for (genvar g = 0; g < N_STATES; g++) begin : g_stb
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_stb[g] <= 1'b0;
            end else begin
                state_stb[g] <= core_ce && (st_nxt == SW'(g));
            end
        end
    end

    assign state_num  = st_q + SW'(1);
    assign mcyc_start = state_stb[0];
endmodule

// File: rtl/mcyc_clkgen.sv
// Top of the dual-rate machine-cycle clock generator.
// Connects the control register, the divider/switch and the state
// sequencer. Assumes clk is the free-running oscillator and rst_n is
// synchronous to it.
module mcyc_clkgen
    import mcyc_clkgen_pkg::*;
#(
    parameter int SFR_AW   = DEF_SFR_AW,
    parameter int SFR_DW   = DEF_SFR_DW,
    parameter int CTL_ADDR = DEF_CTL_ADDR,
    parameter int MODE_BIT = DEF_MODE_BIT,
    parameter int N_STATES = DEF_N_STATES,
    localparam int SW      = $clog2(N_STATES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sfr_we,
    input  logic [SFR_AW-1:0]   sfr_addr,
    input  logic [SFR_DW-1:0]   sfr_wdata,
    output logic                core_ce,
    output logic                half_clk,
    output logic                dbl_mode,
    output logic [SW-1:0]       state_num,
    output logic [N_STATES-1:0] state_stb,
    output logic                mcyc_start
);
    clk_mode_e mode_req;
    clk_mode_e mode_act;

    mcyc_ctl_reg #(
        .SFR_AW   (SFR_AW),
        .SFR_DW   (SFR_DW),
        .CTL_ADDR (CTL_ADDR),
        .MODE_BIT (MODE_BIT)
    ) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (sfr_we),
        .addr     (sfr_addr),
        .wdata    (sfr_wdata),
        .mode_req (mode_req)
    );

    mcyc_div_switch u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_req (mode_req),
        .half_clk (half_clk),
        .mode_act (mode_act),
        .core_ce  (core_ce)
    );

    mcyc_state_seq #(
        .N_STATES (N_STATES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_ce    (core_ce),
        .state_num  (state_num),
        .state_stb  (state_stb),
        .mcyc_start (mcyc_start)
    );

    assign dbl_mode = (mode_act == CLK_DBL);
endmodule

// File: rtl/mcyc_clkgen_chk.sv
// Property checker for mcyc_clkgen, attached by bind.
module mcyc_clkgen_chk #(
    parameter int N_STATES = 6,
    localparam int SW      = $clog2(N_STATES + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                core_ce,
    input logic                half_clk,
    input logic                dbl_mode,
    input logic [SW-1:0]       state_num,
    input logic [N_STATES-1:0] state_stb,
    input logic                mcyc_start
);
    AST_RATE_ON_DIV_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_mode != $past(dbl_mode)) |-> (half_clk && !$past(half_clk))); // R5
    AST_STD_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl_mode && core_ce) |=> !core_ce); // R2
    AST_DBL_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_mode |-> core_ce); // R3
    AST_NO_LONG_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !core_ce |=> core_ce); // R6
    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(state_stb)); // R7
    AST_STB_AFTER_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (|state_stb) |-> $past(core_ce)); // R7
    AST_START_AT_S1: assert property (@(posedge clk) disable iff (!rst_n)
        mcyc_start |-> (state_num == SW'(1))); // R8
endmodule

bind mcyc_clkgen mcyc_clkgen_chk #(.N_STATES(N_STATES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_ce    (core_ce),
    .half_clk   (half_clk),
    .dbl_mode   (dbl_mode),
    .state_num  (state_num),
    .state_stb  (state_stb),
    .mcyc_start (mcyc_start)
);

// File: tb/mcyc_clkgen_tb_top.sv
// Self-checking bench for mcyc_clkgen.
module mcyc_clkgen_tb_top;
    localparam int  CLK_NS = 4;
    localparam int  WD_CYC = 100000;
    localparam int  NVEC   = 7;

    typedef struct packed {
        logic       we;
        logic [7:0] addr;
        logic [7:0] data;
        logic       exp_dbl;
        logic [4:0] exp_per;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        vec_t'({1'b1, 8'h8F, 8'h01, 1'b1, 5'd6}),   // R4 set double, R3
        vec_t'({1'b1, 8'h8E, 8'h00, 1'b1, 5'd6}),   // R4 other address ignored
        vec_t'({1'b1, 8'h8F, 8'hFE, 1'b0, 5'd12}),  // R4 upper bits ignored, R2
        vec_t'({1'b0, 8'h8F, 8'h01, 1'b0, 5'd12}),  // R9 no strobe
        vec_t'({1'b1, 8'h8F, 8'h03, 1'b1, 5'd6}),   // R4, R3
        vec_t'({1'b1, 8'h0F, 8'h00, 1'b1, 5'd6}),   // R4 partial address match
        vec_t'({1'b1, 8'h8F, 8'h00, 1'b0, 5'd12})   // R2
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sfr_we = 1'b0;
    logic [7:0] sfr_addr = '0;
    logic [7:0] sfr_wdata = '0;
    logic       core_ce;
    logic       half_clk;
    logic       dbl_mode;
    logic [2:0] state_num;
    logic [5:0] state_stb;
    logic       mcyc_start;

    int n_chk  = 0;
    int n_fail = 0;
    bit mon_en = 1'b0;
    int gap_cnt = 1;
    int gap_viol = 0;
    int gap_max = 0;

    always #(CLK_NS / 2) clk = ~clk;

    mcyc_clkgen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sfr_we     (sfr_we),
        .sfr_addr   (sfr_addr),
        .sfr_wdata  (sfr_wdata),
        .core_ce    (core_ce),
        .half_clk   (half_clk),
        .dbl_mode   (dbl_mode),
        .state_num  (state_num),
        .state_stb  (state_stb),
        .mcyc_start (mcyc_start)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sfr_write(input logic we, input logic [7:0] a, input logic [7:0] d);
        @(posedge clk) #1;
        sfr_we = we; sfr_addr = a; sfr_wdata = d;
        @(posedge clk) #1;
        sfr_we = 1'b0;
    endtask

    task automatic meas_period(output int per);
        int k = 0;
        @(negedge clk);
        while (!mcyc_start && k < 64) begin @(negedge clk); k++; end
        per = 0;
        do begin @(negedge clk); per++; end while (!mcyc_start && per < 64);
    endtask

    task automatic count_ce(output int n);
        n = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (core_ce) n++;
        end
    endtask

    // Exact switch latency: 1 cycle if half_clk reads 0 after the write edge.
    task automatic switch_latency(input logic [7:0] d, input logic old_m);
        logic h0;
        sfr_write(1'b1, 8'h8F, d);
        @(negedge clk);
        h0 = half_clk;
        chk("R5 rate unchanged right after write", int'(dbl_mode), int'(old_m));
        @(negedge clk);
        if (!h0) begin
            chk("R5 rate applied after 1 cycle", int'(dbl_mode), int'(d[0]));
            chk("R5 divided clock high at change", int'(half_clk), 1);
        end else begin
            chk("R5 rate held while divider falls", int'(dbl_mode), int'(old_m));
            @(negedge clk);
            chk("R5 rate applied after 2 cycles", int'(dbl_mode), int'(d[0]));
            chk("R5 divided clock high at change", int'(half_clk), 1);
        end
    endtask

    // Gap monitor between enable pulses.
    always @(negedge clk) begin
        if (mon_en) begin
            if (core_ce) begin
                if (gap_cnt > gap_max) gap_max = gap_cnt;
                if (gap_cnt > 2) gap_viol++;
                gap_cnt = 1;
            end else begin
                gap_cnt++;
            end
        end
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected 0 (cycles exhausted)", WD_CYC);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int per;
        int nce;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset dbl_mode", int'(dbl_mode), 0);
        chk("R1 reset half_clk", int'(half_clk), 0);
        chk("R1 reset core_ce", int'(core_ce), 0);
        chk("R1 reset state_num", int'(state_num), 6);
        chk("R1 reset state_stb", int'(state_stb), 0);
        chk("R1 reset mcyc_start", int'(mcyc_start), 0);
        @(posedge clk) #1;
        rst_n = 1'b1;
        mon_en = 1'b1;

        meas_period(per);
        chk("R2 standard period after reset", per, 12);

        for (int v = 0; v < NVEC; v++) begin
            sfr_write(VECS[v].we, VECS[v].addr, VECS[v].data);
            repeat (4) @(posedge clk);
            @(negedge clk);
            chk($sformatf("R4/R9 vec%0d applied rate", v), int'(dbl_mode), int'(VECS[v].exp_dbl));
            meas_period(per);
            chk($sformatf("R2/R3 vec%0d machine-cycle period", v), per, int'(VECS[v].exp_per));
            count_ce(nce);
            chk($sformatf("R2/R3 vec%0d enables per 12 cycles", v), nce,
                VECS[v].exp_dbl ? 12 : 6);
        end

        // R7 and R8: strobe order across one standard machine cycle.
        begin
            int exp_s = 1;
            int nstb = 0;
            int bad = 0;
            @(negedge clk);
            while (!mcyc_start) @(negedge clk);
            chk("R8 start coincides with state 1", int'(state_num), 1);
            for (int i = 0; i < 12; i++) begin
                if (i > 0) @(negedge clk);
                if (state_stb != 6'd0) begin
                    nstb++;
                    if (state_num != 3'(exp_s)) bad++;
                    if (state_stb != 6'(1 << (exp_s - 1))) bad++;
                    exp_s = (exp_s == 6) ? 1 : exp_s + 1;
                end
            end
            chk("R7 strobes per machine cycle", nstb, 6);
            chk("R7 strobe order mismatches", bad, 0);
        end

        // R5: exact latency in both directions and both divider phases.
        for (int p = 0; p < 2; p++) begin
            repeat (p + 1) @(posedge clk);
            switch_latency(8'h01, 1'b0);
            repeat (p + 3) @(posedge clk);
            switch_latency(8'h00, 1'b1);
        end

        // R6: rapid back-to-back toggling of the rate.
        for (int t = 0; t < 8; t++) begin
            sfr_write(1'b1, 8'h8F, 8'(t & 1) ^ 8'h01);
        end
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R6 enable gaps over 2 cycles", gap_viol, 0);
        chk("R6 largest enable gap", gap_max, 2);

        // R1: reset while double rate is active.
        sfr_write(1'b1, 8'h8F, 8'h01);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R3 double rate before reset", int'(dbl_mode), 1);
        mon_en = 1'b0;
        @(posedge clk) #1;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 reset leaves double rate", int'(dbl_mode), 0);
        chk("R1 reset state_num in double", int'(state_num), 6);
        chk("R1 reset state_stb in double", int'(state_stb), 0);
        @(posedge clk) #1;
        rst_n = 1'b1;
        meas_period(per);
        chk("R1 standard period after second reset", per, 12);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule